// File: doc/BRIEF.md
# Guarded Instruction-Count Snapshot Register

This block holds a 64-bit snapshot of a free-running instruction counter. The snapshot is refreshed on every clock edge where a capture strobe reports a successful capture event. It keeps its value until the next such event. Software reads the snapshot through a single read request. The request carries the system-register encoding fields and the privilege level (0 to 3) of the requester.

Each read goes through a chain of permission checks that runs in a fixed order. The chain uses several inputs: whether level 3 is implemented, whether level 2 is active, whether fine-grained traps exist, a monitor-level enable, a monitor-level fine-grained enable, a hypervisor read-permit bit, and two undefined-result policy bits. The first is an early policy that outranks the fine-grained trap. The second is a late policy that decides between undefined and a trap to level 3.

The outcome is registered and returned one cycle after the request. It comes with a valid flag, a 2-bit outcome code, the read data (zero unless the outcome is data), and a syndrome class for traps. The block has no write path.

Top module: `snap_reg_guard`

## Requirements
- R1: The snapshot resets to zero. On each rising edge where `cap_valid` is high, it loads `cnt_value`; otherwise it keeps its value.
- R2: A read is accepted only when the encoding fields are op0=2, op1=0, CRn=14, CRm=12 and op2=0. A request with any other encoding produces no response (`rsp_valid` stays low).
- R3: An accepted request sampled on edge N gives `rsp_valid` high for exactly the cycle after edge N. The outcome codes are 0 = data, 1 = undefined, 2 = trap to level 2 and 3 = trap to level 3.
- R4: A read from level 0 always gives outcome 1.
- R5: At level 1 or level 2, if level 3 exists, `undef_early` is 1 and `mon_en` is 0, the outcome is 1. This check wins over every later check.
- R6: At level 1 only, when R5 does not apply, the outcome is 2 if all of the following hold: `l2_active` is 1, `fgt_present` is 1, and either (level 3 exists and `mon_fgt_en` is 0) or `hyp_rd_allow` is 0.
- R7: At level 1 or level 2, when no earlier check applies, level 3 exists and `mon_en` is 0, the outcome is 1 if `undef_late` is 1 and 3 otherwise. If level 3 does not exist, `mon_en` has no effect.
- R8: At level 2 the fine-grained inputs have no effect on the outcome.
- R9: A read at level 3 always gives outcome 0, whatever the control inputs are.
- R10: `rsp_syndrome` is 0x18 for outcomes 2 and 3, and 0 for outcomes 0 and 1.
- R11: For outcome 0, `rsp_data` is the snapshot value held just before the request edge. A capture on that same edge is not visible in this response. For any other outcome, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_value | input | 64 | Current instruction counter value |
| cap_valid | input | 1 | Capture event succeeded this cycle |
| rd_req | input | 1 | Read request strobe |
| rd_op0 | input | 2 | Encoding field op0 |
| rd_op1 | input | 3 | Encoding field op1 |
| rd_crn | input | 4 | Encoding field CRn |
| rd_crm | input | 4 | Encoding field CRm |
| rd_op2 | input | 3 | Encoding field op2 |
| rd_level | input | 2 | Privilege level of the requester |
| has_l3 | input | 1 | Level 3 is implemented |
| l2_active | input | 1 | Level 2 is enabled for the requester |
| fgt_present | input | 1 | Fine-grained traps are implemented |
| mon_fgt_en | input | 1 | Monitor-level fine-grained enable |
| hyp_rd_allow | input | 1 | Hypervisor read-permit bit (0 traps level-1 reads) |
| mon_en | input | 1 | Monitor-level access enable |
| undef_early | input | 1 | Undefined result takes priority over the fine-grained trap |
| undef_late | input | 1 | Monitor-disabled reads are undefined instead of trapping |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | Outcome code |
| rsp_data | output | 64 | Read data |
| rsp_syndrome | output | 6 | Trap syndrome class |

## Verification
The bench checks the order of the checks. A level-1 read with both the early undefined policy and a hypervisor trap pending must come back undefined. A read with the monitor disabled but the fine-grained trap pending must trap to level 2; a design that reordered the chain would give the other result in each case. Level-2 reads with the hypervisor bit cleared must return data, which catches a design that applied the fine-grained trap at every level. The bench also reads with the monitor disabled on a part without level 3, which a design missing the level-3 presence gate would refuse. Finally, it issues a read and a capture on the same edge: a design that forwarded the new count would return the wrong word. It also checks that refused reads leak no data.

// File: rtl/snapchk_pkg.sv
package snapchk_pkg;
    localparam int SNAP_W = 64;
    localparam int SYN_W  = 6;

    localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

    localparam logic [1:0] ENC_OP0 = 2'b10;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b1110;
    localparam logic [3:0] ENC_CRM = 4'b1100;
    localparam logic [2:0] ENC_OP2 = 3'b000;

    typedef enum logic [1:0] {
        OUT_DATA    = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    typedef struct packed {
        logic              valid;
        outcome_e          code;
        logic [SNAP_W-1:0] data;
        logic [SYN_W-1:0]  syn;
    } rsp_t;
endpackage

// File: rtl/snap_capture.sv
module snap_capture #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_value,
    input  logic         cap_valid,
    output logic [W-1:0] snap
);
    logic [W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (cap_valid) snap_d = cnt_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap = snap_q;

    // R1: a capture loads the counter value
    p_capture_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> snap_q == $past(cnt_value));
    // R1: without a capture the snapshot holds
    p_capture_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> $stable(snap_q));
endmodule

// File: rtl/snap_access_judge.sv
module snap_access_judge
    import snapchk_pkg::*;
(
    input  logic [1:0] rd_op0,
    input  logic [2:0] rd_op1,
    input  logic [3:0] rd_crn,
    input  logic [3:0] rd_crm,
    input  logic [2:0] rd_op2,
    input  logic [1:0] rd_level,
    input  logic       has_l3,
    input  logic       l2_active,
    input  logic       fgt_present,
    input  logic       mon_fgt_en,
    input  logic       hyp_rd_allow,
    input  logic       mon_en,
    input  logic       undef_early,
    input  logic       undef_late,
    output logic       enc_hit,
    output outcome_e   verdict
);
    logic mon_block;
    logic early_undef;
    logic fgt_trap;

    always_comb begin
        enc_hit = (rd_op0 == ENC_OP0) && (rd_op1 == ENC_OP1) &&
                  (rd_crn == ENC_CRN) && (rd_crm == ENC_CRM) &&
                  (rd_op2 == ENC_OP2);

        mon_block   = has_l3 && !mon_en;
        early_undef = mon_block && undef_early;
        fgt_trap    = l2_active && fgt_present &&
                      ((has_l3 && !mon_fgt_en) || !hyp_rd_allow);

        verdict = OUT_DATA;
        case (rd_level)
            2'd0: verdict = OUT_UNDEF;
            2'd1: begin
                if (early_undef)    verdict = OUT_UNDEF;
                else if (fgt_trap)  verdict = OUT_TRAP_L2;
                else if (mon_block) verdict = undef_late ? OUT_UNDEF : OUT_TRAP_L3;
            end
            2'd2: begin
                if (early_undef)    verdict = OUT_UNDEF;
                else if (mon_block) verdict = undef_late ? OUT_UNDEF : OUT_TRAP_L3;
            end
            default: verdict = OUT_DATA;
        endcase
    end
endmodule

// File: rtl/snap_reg_guard.sv
module snap_reg_guard
    import snapchk_pkg::*;
#(
    parameter int DATA_W = SNAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_value,
    input  logic              cap_valid,
    input  logic              rd_req,
    input  logic [1:0]        rd_op0,
    input  logic [2:0]        rd_op1,
    input  logic [3:0]        rd_crn,
    input  logic [3:0]        rd_crm,
    input  logic [2:0]        rd_op2,
    input  logic [1:0]        rd_level,
    input  logic              has_l3,
    input  logic              l2_active,
    input  logic              fgt_present,
    input  logic              mon_fgt_en,
    input  logic              hyp_rd_allow,
    input  logic              mon_en,
    input  logic              undef_early,
    input  logic              undef_late,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_data,
    output logic [SYN_W-1:0]  rsp_syndrome
);
    logic [DATA_W-1:0] snap;
    logic              enc_hit;
    outcome_e          verdict;

    typedef struct packed {
        logic              valid;
        outcome_e          code;
        logic [DATA_W-1:0] data;
        logic [SYN_W-1:0]  syn;
    } resp_t;

    resp_t rsp_d, rsp_q;

    snap_capture #(.W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_value(cnt_value),
        .cap_valid(cap_valid),
        .snap     (snap)
    );

    snap_access_judge u_judge (
        .rd_op0      (rd_op0),
        .rd_op1      (rd_op1),
        .rd_crn      (rd_crn),
        .rd_crm      (rd_crm),
        .rd_op2      (rd_op2),
        .rd_level    (rd_level),
        .has_l3      (has_l3),
        .l2_active   (l2_active),
        .fgt_present (fgt_present),
        .mon_fgt_en  (mon_fgt_en),
        .hyp_rd_allow(hyp_rd_allow),
        .mon_en      (mon_en),
        .undef_early (undef_early),
        .undef_late  (undef_late),
        .enc_hit     (enc_hit),
        .verdict     (verdict)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.code  = OUT_DATA;
        if (rd_req && enc_hit) begin
            rsp_d.valid = 1'b1;
            rsp_d.code  = verdict;
            rsp_d.data  = (verdict == OUT_DATA) ? snap : '0;
            rsp_d.syn   = (verdict == OUT_TRAP_L2 || verdict == OUT_TRAP_L3)
                          ? SYN_SYSREG : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q      <= '0;
            rsp_q.code <= OUT_DATA;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_code     = rsp_q.code;
    assign rsp_data     = rsp_q.data;
    assign rsp_syndrome = rsp_q.syn;

    // R3: no request, no response in the next cycle
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    // R4: level-0 reads are refused as undefined
    p_level0_undef_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && enc_hit && rd_level == 2'd0) |=> (rsp_valid && rsp_code == 2'd1));
    // R9: level-3 reads always return data
    p_level3_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && enc_hit && rd_level == 2'd3) |=> (rsp_valid && rsp_code == 2'd0));
    // R10: trap outcomes carry the syndrome class
    p_trap_syndrome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code[1]) |-> rsp_syndrome == SYN_SYSREG);
    // R11: refused reads leak no data
    p_refused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> rsp_data == '0);
    // R11: granted reads return the pre-edge snapshot
    p_grant_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && enc_hit && verdict == OUT_DATA) |=> rsp_data == $past(snap));
endmodule

// File: tb/snap_reg_guard_bench.sv
module snap_reg_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt_value;
    logic        cap_valid, rd_req;
    logic [1:0]  rd_op0;
    logic [2:0]  rd_op1;
    logic [3:0]  rd_crn, rd_crm;
    logic [2:0]  rd_op2;
    logic [1:0]  rd_level;
    logic        has_l3, l2_active, fgt_present, mon_fgt_en, hyp_rd_allow;
    logic        mon_en, undef_early, undef_late;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [63:0] rsp_data;
    logic [5:0]  rsp_syndrome;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    snap_reg_guard u_snap_reg_guard (
        .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cap_valid(cap_valid),
        .rd_req(rd_req), .rd_op0(rd_op0), .rd_op1(rd_op1), .rd_crn(rd_crn),
        .rd_crm(rd_crm), .rd_op2(rd_op2), .rd_level(rd_level), .has_l3(has_l3),
        .l2_active(l2_active), .fgt_present(fgt_present), .mon_fgt_en(mon_fgt_en),
        .hyp_rd_allow(hyp_rd_allow), .mon_en(mon_en), .undef_early(undef_early),
        .undef_late(undef_late), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_data(rsp_data), .rsp_syndrome(rsp_syndrome)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_enc_ok();
        rd_op0 = 2'b10; rd_op1 = 3'b000; rd_crn = 4'b1110; rd_crm = 4'b1100; rd_op2 = 3'b000;
    endtask

    task automatic set_ctl(input logic l3, input logic l2a, input logic fgt, input logic mfgt,
                           input logic hyp, input logic men, input logic ue, input logic ul);
        has_l3 = l3; l2_active = l2a; fgt_present = fgt; mon_fgt_en = mfgt;
        hyp_rd_allow = hyp; mon_en = men; undef_early = ue; undef_late = ul;
    endtask

    task automatic capture(input logic [63:0] v);
        @(negedge clk);
        cnt_value = v; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    // issues one read, checks code, data, syndrome, and that valid drops after
    task automatic read_expect(input string req, input logic [1:0] lvl, input logic [1:0] code,
                               input logic [63:0] data);
        @(negedge clk);
        set_enc_ok(); rd_level = lvl; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({req, " code"}, {62'd0, rsp_code}, {62'd0, code});
        check({req, " data"}, rsp_data, data);
        check({req, " syndrome"}, {58'd0, rsp_syndrome}, code[1] ? 64'h18 : 64'h0);
        @(negedge clk);
        check({req, " R3 single-cycle valid"}, {63'd0, rsp_valid}, 64'd0);
    endtask

    localparam logic [63:0] SNAP_A = 64'hDEAD_BEEF_0123_4567;
    localparam logic [63:0] SNAP_B = 64'hFFFF_0000_AAAA_5555;

    task automatic t_reset();
        check("R3 reset valid low", {63'd0, rsp_valid}, 64'd0);
        set_ctl(1, 1, 1, 1, 1, 1, 0, 0);
        read_expect("R1 reset snapshot zero", 2'd3, 2'd0, 64'd0);
    endtask

    task automatic t_capture();
        capture(SNAP_A);
        read_expect("R1 captured value", 2'd3, 2'd0, SNAP_A);
        @(negedge clk); cnt_value = 64'h1234;
        read_expect("R1 hold without strobe", 2'd3, 2'd0, SNAP_A);
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        set_enc_ok(); rd_level = 2'd3; rd_req = 1'b1; cnt_value = SNAP_B; cap_valid = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; cap_valid = 1'b0;
        check("R11 same-edge capture not visible", rsp_data, SNAP_A);
        read_expect("R11 capture visible after", 2'd3, 2'd0, SNAP_B);
    endtask

    task automatic t_encoding();
        @(negedge clk);
        set_enc_ok(); rd_crm = 4'b1101; rd_level = 2'd3; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check("R2 bad CRm no response", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        set_enc_ok(); rd_op1 = 3'b011; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check("R2 bad op1 no response", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_level0();
        set_ctl(1, 1, 1, 1, 1, 1, 0, 0);
        read_expect("R4 level 0 undefined", 2'd0, 2'd1, 64'd0);
    endtask

    task automatic t_level1();
        set_ctl(1, 1, 1, 1, 1, 1, 0, 0);
        read_expect("R6 level 1 permitted", 2'd1, 2'd0, SNAP_B);
        set_ctl(1, 1, 1, 1, 0, 0, 1, 0);
        read_expect("R5 early undef beats fgt trap", 2'd1, 2'd1, 64'd0);
        set_ctl(1, 1, 1, 1, 0, 1, 0, 0);
        read_expect("R6 hyp bit clear traps L2", 2'd1, 2'd2, 64'd0);
        set_ctl(1, 1, 1, 0, 1, 1, 0, 0);
        read_expect("R6 monitor fgt disable traps L2", 2'd1, 2'd2, 64'd0);
        set_ctl(0, 1, 1, 0, 1, 1, 0, 0);
        read_expect("R6 monitor fgt ignored w/o L3", 2'd1, 2'd0, SNAP_B);
        set_ctl(1, 0, 1, 1, 0, 1, 0, 0);
        read_expect("R6 no trap when L2 inactive", 2'd1, 2'd0, SNAP_B);
        set_ctl(1, 1, 0, 1, 0, 1, 0, 0);
        read_expect("R6 no trap without fgt", 2'd1, 2'd0, SNAP_B);
        set_ctl(1, 1, 1, 1, 0, 0, 0, 1);
        read_expect("R6 fgt trap beats monitor check", 2'd1, 2'd2, 64'd0);
        set_ctl(1, 1, 1, 1, 1, 0, 0, 0);
        read_expect("R7 monitor disable traps L3", 2'd1, 2'd3, 64'd0);
        set_ctl(1, 1, 1, 1, 1, 0, 0, 1);
        read_expect("R7 late undef policy", 2'd1, 2'd1, 64'd0);
        set_ctl(0, 0, 0, 1, 1, 0, 1, 1);
        read_expect("R7 monitor ignored w/o L3", 2'd1, 2'd0, SNAP_B);
    endtask

    task automatic t_level2_3();
        set_ctl(1, 1, 1, 0, 0, 1, 0, 0);
        read_expect("R8 level 2 ignores fgt", 2'd2, 2'd0, SNAP_B);
        set_ctl(1, 1, 1, 1, 1, 0, 0, 0);
        read_expect("R7 level 2 traps L3", 2'd2, 2'd3, 64'd0);
        set_ctl(1, 1, 1, 1, 1, 0, 0, 1);
        read_expect("R7 level 2 late undef", 2'd2, 2'd1, 64'd0);
        set_ctl(1, 1, 1, 1, 1, 0, 1, 0);
        read_expect("R5 level 2 early undef", 2'd2, 2'd1, 64'd0);
        set_ctl(1, 1, 1, 0, 0, 0, 1, 1);
        read_expect("R9 level 3 always data", 2'd3, 2'd0, SNAP_B);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_value = '0; cap_valid = 1'b0; rd_req = 1'b0; rd_level = 2'd0;
        set_enc_ok();
        set_ctl(1, 1, 1, 1, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_same_edge();
        t_encoding();
        t_level0();
        t_level1();
        t_level2_3();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule